// File: doc/BRIEF.md
# Read-Aligned Transmit Burst Controller

This block decides where a transmit read-DMA burst ends and which pending DMA channel owns the read path next. It observes each completed read word through a one-cycle `word_done` strobe that carries the word's byte address. From that it decides whether the burst stops after the word. When it stops the burst, it reports the address at which the next burst should start. The bus protocol, the FIFO storage and the descriptor handling are outside this block.

With alignment enabled, a stop is only ever taken after the last word of a cache line, so the following burst starts on a line-aligned address. Two conditions ask for a stop. The first is a transmit FIFO that is nearly full. The second is a byte-count arbitration limit that has been reached while another channel is waiting. With alignment disabled, either condition takes effect on the word where it is seen. All pins are plain level or strobe controls: no data passes through the block and nothing stalls it, so there is no back-pressure. `word_done` may be high on any number of consecutive cycles.

Top module: `ra_burst_ctrl`

## Requirements
- R1: After reset, `burst_end` is 0, `grant` selects channel 0 (value 4'b0001 with four channels) and `next_addr` is 0.
- R2: With `align_en`=1, a stop is taken only on a word whose address plus 4 is a multiple of the line size in bytes. `burst_end` is then high in the cycle after that `word_done`, and `next_addr` equals the word's address plus 4.
- R3: With `align_en`=0, a word completed while `fifo_afull` is high ends the burst on that same word. `burst_end` follows one cycle later and `next_addr` is that address plus 4.
- R4: `cls16`=0 selects a line of 8 words (32 bytes) and `cls16`=1 selects a line of 16 words (64 bytes).
- R5: The byte counter adds 4 per completed word for the channel holding the grant. A limit is reached on the word that makes the count reach or pass `max_bytes`, provided `arb_en`=1 and `max_bytes` is nonzero. Once reached, the limit stays pending until a switch. A switch happens on a stop word, provided another channel requests. The counter restarts at 0 when the grant moves.
- R6: On a switch, the new grant is the first requesting channel found by counting upward from the current channel, wrapping past the highest index.
- R7: If the limit is reached but no other channel requests, the burst is not ended for that reason and the grant stays.
- R8: With `arb_en`=0 the byte count never causes a stop or a switch.
- R9: `grant` is always one-hot and changes only in a cycle where `burst_end` is high.
- R10: A `fifo_afull` pulse seen in any cycle is remembered. It is honoured at the next permitted stop word and cleared by that stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| align_en | input | 1 | Enables cutting bursts only at line boundaries |
| cls16 | input | 1 | Line size select: 0 = 8 words, 1 = 16 words |
| fifo_afull | input | 1 | Transmit FIFO nearly full |
| arb_en | input | 1 | Enables byte-count arbitration |
| max_bytes | input | CNT_W | Byte limit per grant |
| req | input | N_CH | Pending request per DMA channel |
| word_done | input | 1 | One read word completed this cycle |
| cur_addr | input | ADDR_W | Byte address of the completed word |
| burst_end | output | 1 | Burst stopped after the previous word |
| grant | output | N_CH | One-hot owning channel |
| next_addr | output | ADDR_W | Start address of the next burst |

## Verification
The checker covers the invariants on every cycle. The grant stays one-hot and moves only together with a stop pulse. Each stop follows a completed word. A stop taken with alignment on leaves a line-aligned restart address for the selected line size. A newly granted channel was requesting. Which word the stop lands on is only shown by the bench's scenarios: the remembered FIFO pulse, the difference between 8- and 16-word lines, the counter threshold, the solo-requester case and the round-robin wrap order.

// File: rtl/ra_pkg.sv
package ra_pkg;
  localparam int unsigned LINE_WORDS_SMALL = 8;
  localparam int unsigned LINE_WORDS_LARGE = 16;

  typedef struct packed {
    logic afull_cause;
    logic switch_cause;
  } stop_cause_t;
endpackage

// File: rtl/ra_line_detect.sv
module ra_line_detect #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              cls16,
  output logic              last_in_line,
  output logic [ADDR_W-1:0] addr_after
);
  import ra_pkg::*;
  localparam logic [ADDR_W-1:0] MASK_S = ADDR_W'(LINE_WORDS_SMALL * WORD_BYTES - 1);
  localparam logic [ADDR_W-1:0] MASK_L = ADDR_W'(LINE_WORDS_LARGE * WORD_BYTES - 1);

  logic [ADDR_W-1:0] mask;
  always_comb begin
    mask         = cls16 ? MASK_L : MASK_S;
    addr_after   = addr + ADDR_W'(WORD_BYTES);
    last_in_line = ((addr_after & mask) == '0);
  end
endmodule

// File: rtl/ra_byte_counter.sv
module ra_byte_counter #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  input  logic             arb_en,
  input  logic [CNT_W-1:0] max_bytes,
  output logic             limit_hit
);
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic [CNT_W:0]   sum;
  logic             reached;

  always_comb begin
    sum       = {1'b0, cnt_q} + (CNT_W+1)'(WORD_BYTES);
    reached   = inc && arb_en && (max_bytes != '0) && (sum >= {1'b0, max_bytes});
    limit_hit = arb_en && (pend_q || reached);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (clr) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (inc) cnt_q <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
      if (reached) pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ra_rr_pick.sv
module ra_rr_pick #(
  parameter int unsigned N_CH  = 4,
  localparam int unsigned IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [IDX_W-1:0] cur_idx,
  input  logic [N_CH-1:0]  req,
  output logic [IDX_W-1:0] nxt_idx,
  output logic             other_valid
);
  always_comb begin
    nxt_idx     = cur_idx;
    other_valid = 1'b0;
    for (int k = 1; k < int'(N_CH); k++) begin
      int cand;
      cand = (int'(cur_idx) + k) % int'(N_CH);
      if (!other_valid && req[cand]) begin
        other_valid = 1'b1;
        nxt_idx     = IDX_W'(cand);
      end
    end
  end
endmodule

// File: rtl/ra_burst_ctrl.sv
module ra_burst_ctrl #(
  parameter int unsigned N_CH       = 4,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              align_en,
  input  logic              cls16,
  input  logic              fifo_afull,
  input  logic              arb_en,
  input  logic [CNT_W-1:0]  max_bytes,
  input  logic [N_CH-1:0]   req,
  input  logic              word_done,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic              burst_end,
  output logic [N_CH-1:0]   grant,
  output logic [ADDR_W-1:0] next_addr
);
  import ra_pkg::*;
  localparam int unsigned IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic [IDX_W-1:0]  cur_idx_q, nxt_idx;
  logic              other_valid, last_in_line, limit_hit;
  logic [ADDR_W-1:0] addr_after;
  logic              afull_pend_q, stop, do_switch;
  stop_cause_t       cause;

  ra_line_detect #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) line_i (
    .addr(cur_addr), .cls16(cls16),
    .last_in_line(last_in_line), .addr_after(addr_after)
  );

  ra_byte_counter #(.CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)) cnt_i (
    .clk(clk), .rst_n(rst_n), .inc(word_done), .clr(do_switch),
    .arb_en(arb_en), .max_bytes(max_bytes), .limit_hit(limit_hit)
  );

  ra_rr_pick #(.N_CH(N_CH)) rr_i (
    .cur_idx(cur_idx_q), .req(req),
    .nxt_idx(nxt_idx), .other_valid(other_valid)
  );

  always_comb begin
    cause.afull_cause  = fifo_afull || afull_pend_q;
    cause.switch_cause = limit_hit && other_valid;
    stop      = word_done && (cause != '0) && (!align_en || last_in_line);
    do_switch = stop && cause.switch_cause;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_idx_q    <= '0;
      afull_pend_q <= 1'b0;
      burst_end    <= 1'b0;
      next_addr    <= '0;
    end else begin
      burst_end <= stop;
      if (stop) begin
        next_addr    <= addr_after;
        afull_pend_q <= 1'b0;
      end else if (fifo_afull) begin
        afull_pend_q <= 1'b1;
      end
      if (do_switch) cur_idx_q <= nxt_idx;
    end
  end

  always_comb begin
    grant = '0;
    grant[cur_idx_q] = 1'b1;
  end
endmodule

// File: rtl/ra_burst_ctrl_chk.sv
module ra_burst_ctrl_chk #(
  parameter int unsigned N_CH       = 4,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned WORD_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              align_en,
  input logic              cls16,
  input logic              word_done,
  input logic [N_CH-1:0]   req,
  input logic [N_CH-1:0]   grant,
  input logic              burst_end,
  input logic [ADDR_W-1:0] next_addr
);
  import ra_pkg::*;
  localparam logic [ADDR_W-1:0] MS = ADDR_W'(LINE_WORDS_SMALL * WORD_BYTES - 1);
  localparam logic [ADDR_W-1:0] ML = ADDR_W'(LINE_WORDS_LARGE * WORD_BYTES - 1);

  assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(grant));

  assert_grant_moves_on_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(grant) |-> burst_end);

  assert_end_follows_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |-> $past(word_done));

  assert_aligned_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_end && $past(align_en)) |-> ((next_addr & ($past(cls16) ? ML : MS)) == '0));

  assert_new_owner_requested_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(grant) |-> ((grant & $past(req)) != '0));
endmodule

bind ra_burst_ctrl ra_burst_ctrl_chk #(.N_CH(N_CH), .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) chk_i (
  .clk(clk), .rst_n(rst_n), .align_en(align_en), .cls16(cls16),
  .word_done(word_done), .req(req), .grant(grant),
  .burst_end(burst_end), .next_addr(next_addr)
);

// File: tb/ra_burst_ctrl_tb_top.sv
module ra_burst_ctrl_tb_top;
  localparam int N_CH = 4, ADDR_W = 32, CNT_W = 16;
  // fields: align cls16 afull arb req[4] max[8] addr[16] | exp_end exp_gidx[2] exp_na[16]
  localparam int VW = 51;
  localparam int NV = 16;
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'b1000, 4'b0001, 8'd0, 16'h0100, 1'b0, 2'd0, 16'h0000}, // R2 mid-line
    {4'b1010, 4'b0001, 8'd0, 16'h0104, 1'b0, 2'd0, 16'h0000}, // R10 afull latched
    {4'b1000, 4'b0001, 8'd0, 16'h0118, 1'b0, 2'd0, 16'h0000}, // R2 not last
    {4'b1000, 4'b0001, 8'd0, 16'h011C, 1'b1, 2'd0, 16'h0120}, // R2 R10 stop at line end
    {4'b1000, 4'b0001, 8'd0, 16'h013C, 1'b0, 2'd0, 16'h0120}, // R10 cleared by stop
    {4'b0010, 4'b0001, 8'd0, 16'h0144, 1'b1, 2'd0, 16'h0148}, // R3 immediate stop
    {4'b0000, 4'b0001, 8'd0, 16'h0148, 1'b0, 2'd0, 16'h0148}, // R3 no cause
    {4'b1110, 4'b0001, 8'd0, 16'h015C, 1'b0, 2'd0, 16'h0148}, // R4 16-word line, no stop
    {4'b1100, 4'b0001, 8'd0, 16'h017C, 1'b1, 2'd0, 16'h0180}, // R4 16-word boundary
    {4'b0000, 4'b1111, 8'd4, 16'h0200, 1'b0, 2'd0, 16'h0180}, // R8 arbitration off
    {4'b0001, 4'b0001, 8'd4, 16'h0204, 1'b0, 2'd0, 16'h0180}, // R7 solo requester
    {4'b0001, 4'b1010, 8'd4, 16'h0208, 1'b1, 2'd1, 16'h020C}, // R5 R6 switch 0->1
    {4'b1001, 4'b1011, 8'd8, 16'h0300, 1'b0, 2'd1, 16'h020C}, // R5 count 4
    {4'b1001, 4'b1011, 8'd8, 16'h0304, 1'b0, 2'd1, 16'h020C}, // R5 limit, not boundary
    {4'b1001, 4'b1011, 8'd8, 16'h031C, 1'b1, 2'd3, 16'h0320}, // R5 R6 switch 1->3
    {4'b0001, 4'b0011, 8'd4, 16'h0400, 1'b1, 2'd0, 16'h0404}  // R6 wrap 3->0
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic align_en = 0, cls16 = 0, fifo_afull = 0, arb_en = 0, word_done = 0;
  logic [CNT_W-1:0] max_bytes = '0;
  logic [N_CH-1:0] req = '0;
  logic [ADDR_W-1:0] cur_addr = '0;
  logic burst_end;
  logic [N_CH-1:0] grant;
  logic [ADDR_W-1:0] next_addr;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ra_burst_ctrl #(.N_CH(N_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .align_en(align_en), .cls16(cls16),
    .fifo_afull(fifo_afull), .arb_en(arb_en), .max_bytes(max_bytes),
    .req(req), .word_done(word_done), .cur_addr(cur_addr),
    .burst_end(burst_end), .grant(grant), .next_addr(next_addr)
  );

  task automatic check(string tag, logic e_end, logic [N_CH-1:0] e_g, logic [ADDR_W-1:0] e_na);
    n_chk++;
    if (burst_end !== e_end || grant !== e_g || next_addr !== e_na) begin
      n_bad++;
      $display("FAIL %s: got end=%0b grant=%b na=%h, expected end=%0b grant=%b na=%h",
               tag, burst_end, grant, next_addr, e_end, e_g, e_na);
    end
  endtask

  task automatic word(logic al, logic c16, logic af, logic ae, logic [N_CH-1:0] rq,
                      logic [7:0] mx, logic [15:0] ad);
    @(negedge clk);
    align_en = al; cls16 = c16; fifo_afull = af; arb_en = ae; req = rq;
    max_bytes = CNT_W'(mx); cur_addr = ADDR_W'(ad); word_done = 1'b1;
    @(negedge clk);
    word_done = 1'b0; fifo_afull = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0, 4'b0001, '0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      word(v[50], v[49], v[48], v[47], v[46:43], v[42:35], v[34:19]);
      check($sformatf("vector %0d (R2-R8)", i), v[18], 4'b0001 << v[17:16], ADDR_W'(v[15:0]));
    end
    // R9: stop pulse lasts one cycle when no further word arrives
    @(negedge clk);
    check("R9 single-cycle pulse", 1'b0, 4'b0001, 32'h0404);
    // R10: afull pulse in an idle cycle, honoured at the next line end
    @(negedge clk);
    fifo_afull = 1'b1;
    @(negedge clk);
    fifo_afull = 1'b0;
    word(1'b1, 1'b0, 1'b0, 1'b0, 4'b0001, 8'd0, 16'h0410);
    check("R10 idle pulse, mid-line", 1'b0, 4'b0001, 32'h0404);
    word(1'b1, 1'b0, 1'b0, 1'b0, 4'b0001, 8'd0, 16'h041C);
    check("R10 idle pulse honoured", 1'b1, 4'b0001, 32'h0420);
    // R4: address 0x43C ends a 16-word line but not with cls16=0 it ends 8-word too; use 0x42C
    word(1'b1, 1'b1, 1'b1, 1'b0, 4'b0001, 8'd0, 16'h042C);
    check("R4 0x42C not a 16-word line end", 1'b0, 4'b0001, 32'h0420);
    // R1: reset in mid-run restores the idle state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset mid-run", 1'b0, 4'b0001, '0);
    rst_n = 1'b1;
    // R10: the latched afull is cleared by reset
    word(1'b1, 1'b0, 1'b0, 1'b0, 4'b0001, 8'd0, 16'h043C);
    check("R10 pending cleared by reset", 1'b0, 4'b0001, '0);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end
endmodule